// File: doc/BRIEF.md
# Stereo Gain, Routing and Soft-Mute Stage

This block sits between the serial-audio receiver and the oversampling filter of an audio output path. It takes one left and one right signed sample per valid strobe. Each output channel first selects its source: silence, the left input, the right input, or the mean of the two. The selected value is then scaled by a stepped attenuation code and by a soft-mute level. Two conditions force both outputs to exact zero: a global disable, and a zero-detect flag that has been enabled.

Attenuation codes arrive on two write ports, one per channel. Each write stores its code in a pending register. When a write carries its load bit, the pending codes of both channels become active together, so the two channels never play at mismatched levels. A common-gain select applies the left active code to both outputs. The soft mute does not cut the signal. It moves a separate mute level by one step per valid sample, down to silence or back up to unity, so the output fades without a click.

Top module: `stereo_gain_mix`

## Requirements
- R1: For a CW-bit code x, the gain is g/2^CW with g = x when x is below the all-ones value and g = 2^CW when x is all ones. Scaling returns floor(s*g/2^CW) and never overflows DW bits. Code 0 gives 0.
- R2: A write to a channel stores its code as that channel's pending code. A write with its load bit at 1 makes both channels' pending codes active in the same cycle, including the code written in that cycle. A write with its load bit at 0 leaves both active codes unchanged.
- R3: When att_common_i is 1, the left active code scales both outputs. When it is 0, each output uses its own channel's active code.
- R4: route_mode_i[1:0] selects the left output's source and route_mode_i[3:2] selects the right output's source. The encoding is 00 zero, 01 right input, 10 left input, 11 floor((left+right)/2), with the sum taken one bit wider. The selected source is then scaled, first by the attenuation code and then by the mute level.
- R5: The mute level is a CW-bit code that uses the R1 gain law. Each valid sample uses the current level. The level then steps down by one toward 0 while mute_i is 1, or up by one toward all ones while mute_i is 0, and it holds at either end.
- R6: A valid sample taken with disable_i at 1 produces 0 on both outputs.
- R7: A valid sample taken with izd_en_i and zero_flag_i both at 1 produces 0 on both outputs. zero_flag_i has no effect while izd_en_i is 0.
- R8: After reset, both pending codes, both active codes and the mute level are all ones (unity), and the outputs are 0 with out_valid_o low.
- R9: out_valid_o rises exactly one cycle after each in_valid_i cycle. The outputs keep their last values when no sample arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample pair strobe |
| in_left_i | input | DW | Left input sample, signed |
| in_right_i | input | DW | Right input sample, signed |
| att_l_wr_i | input | 1 | Left attenuation write strobe |
| att_l_code_i | input | CW | Left attenuation code |
| att_l_load_i | input | 1 | Load bit of the left write |
| att_r_wr_i | input | 1 | Right attenuation write strobe |
| att_r_code_i | input | CW | Right attenuation code |
| att_r_load_i | input | 1 | Load bit of the right write |
| att_common_i | input | 1 | Left code drives both outputs |
| route_mode_i | input | 4 | Two 2-bit source selectors |
| mute_i | input | 1 | Soft-mute request |
| disable_i | input | 1 | Force outputs to zero |
| izd_en_i | input | 1 | Enable zero-flag forcing |
| zero_flag_i | input | 1 | Input has been zero for a long time |
| out_valid_o | output | 1 | Output sample pair strobe |
| out_left_o | output | DW | Left output sample, signed |
| out_right_o | output | DW | Right output sample, signed |

## Verification
The bench builds the block with DW = 16 and CW = 4. The narrow code width leaves only sixteen gain steps, so a full mute fade down and back up fits in about thirty samples. The all-ones unity code and the floor rounding of every step also show up at small, easily checked magnitudes. The narrow sample width places the extreme positive and negative inputs within easy reach, so the average path and the double scaling can be checked at the rails.

// File: rtl/sgm_pkg.sv
package sgm_pkg;
  typedef enum logic [1:0] {
    SRC_ZERO  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_LEFT  = 2'b10,
    SRC_AVG   = 2'b11
  } src_sel_e;
endpackage

// File: rtl/sgm_scale.sv
module sgm_scale #(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic signed [DW-1:0] s_i,
  input  logic        [CW-1:0] code_i,
  output logic signed [DW-1:0] y_o
);
  localparam int PW = DW + CW + 2;
  logic [CW:0] g;
  logic signed [PW-1:0] prod;

  // all-ones code maps to exact unity
  assign g    = (&code_i) ? {1'b1, {CW{1'b0}}} : {1'b0, code_i};
  assign prod = s_i * $signed({1'b0, g});
  assign y_o  = DW'(prod >>> CW);
endmodule

// File: rtl/sgm_route.sv
module sgm_route import sgm_pkg::*; #(
  parameter int DW = 24
) (
  input  logic signed [DW-1:0] left_i,
  input  logic signed [DW-1:0] right_i,
  input  src_sel_e             sel_i,
  output logic signed [DW-1:0] out_o
);
  logic signed [DW:0]   sum;
  logic signed [DW-1:0] avg;

  assign sum = {left_i[DW-1], left_i} + {right_i[DW-1], right_i};
  assign avg = DW'(sum >>> 1);

  always_comb begin
    unique case (sel_i)
      SRC_ZERO:  out_o = '0;
      SRC_RIGHT: out_o = right_i;
      SRC_LEFT:  out_o = left_i;
      default:   out_o = avg;
    endcase
  end
endmodule

// File: rtl/sgm_att_bank.sv
module sgm_att_bank #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_l_i,
  input  logic [CW-1:0] code_l_i,
  input  logic          ld_l_i,
  input  logic          wr_r_i,
  input  logic [CW-1:0] code_r_i,
  input  logic          ld_r_i,
  output logic [CW-1:0] act_l_o,
  output logic [CW-1:0] act_r_o
);
  logic [CW-1:0] pend_l_q, pend_r_q, pend_l_d, pend_r_d;
  logic load;

  assign pend_l_d = wr_l_i ? code_l_i : pend_l_q;
  assign pend_r_d = wr_r_i ? code_r_i : pend_r_q;
  assign load     = (wr_l_i & ld_l_i) | (wr_r_i & ld_r_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l_q <= '1;
      pend_r_q <= '1;
      act_l_o  <= '1;
      act_r_o  <= '1;
    end else begin
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
      if (load) begin
        act_l_o <= pend_l_d;
        act_r_o <= pend_r_d;
      end
    end
  end
endmodule

// File: rtl/sgm_mute_ramp.sv
module sgm_mute_ramp #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          mute_i,
  output logic [CW-1:0] lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= '1;
    end else if (step_i) begin
      if (mute_i && lvl_o != '0)       lvl_o <= lvl_o - 1'b1;
      else if (!mute_i && lvl_o != '1) lvl_o <= lvl_o + 1'b1;
    end
  end
endmodule

// File: rtl/stereo_gain_mix.sv
module stereo_gain_mix import sgm_pkg::*; #(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  input  logic signed [DW-1:0] in_left_i,
  input  logic signed [DW-1:0] in_right_i,
  input  logic                 att_l_wr_i,
  input  logic        [CW-1:0] att_l_code_i,
  input  logic                 att_l_load_i,
  input  logic                 att_r_wr_i,
  input  logic        [CW-1:0] att_r_code_i,
  input  logic                 att_r_load_i,
  input  logic                 att_common_i,
  input  logic        [3:0]    route_mode_i,
  input  logic                 mute_i,
  input  logic                 disable_i,
  input  logic                 izd_en_i,
  input  logic                 zero_flag_i,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] out_left_o,
  output logic signed [DW-1:0] out_right_o
);
  localparam int NCH = 2;

  logic [CW-1:0] act_l, act_r, mute_lvl;
  logic force_zero;
  logic signed [DW-1:0] chan_res [NCH];

  sgm_att_bank #(.CW(CW)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_l_i(att_l_wr_i), .code_l_i(att_l_code_i), .ld_l_i(att_l_load_i),
    .wr_r_i(att_r_wr_i), .code_r_i(att_r_code_i), .ld_r_i(att_r_load_i),
    .act_l_o(act_l), .act_r_o(act_r)
  );

  sgm_mute_ramp #(.CW(CW)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(in_valid_i),
    .mute_i(mute_i), .lvl_o(mute_lvl)
  );

  assign force_zero = disable_i | (izd_en_i & zero_flag_i);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [DW-1:0] routed, attn;
    logic [CW-1:0] code;
    if (c == 0) begin : g_lcode
      assign code = act_l;
    end else begin : g_rcode
      assign code = att_common_i ? act_l : act_r;
    end
    sgm_route #(.DW(DW)) u_route (
      .left_i(in_left_i), .right_i(in_right_i),
      .sel_i(src_sel_e'(route_mode_i[2*c+1:2*c])), .out_o(routed)
    );
    sgm_scale #(.DW(DW), .CW(CW)) u_att (
      .s_i(routed), .code_i(code), .y_o(attn)
    );
    sgm_scale #(.DW(DW), .CW(CW)) u_mute (
      .s_i(attn), .code_i(mute_lvl), .y_o(chan_res[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_left_o  <= '0;
      out_right_o <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_left_o  <= force_zero ? '0 : chan_res[0];
        out_right_o <= force_zero ? '0 : chan_res[1];
      end
    end
  end
endmodule

// File: rtl/sgm_checker.sv
module sgm_checker #(
  parameter int DW = 24,
  parameter int CW = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 in_valid_i,
  input logic                 disable_i,
  input logic                 izd_en_i,
  input logic                 zero_flag_i,
  input logic                 att_l_wr_i,
  input logic                 att_l_load_i,
  input logic                 att_r_wr_i,
  input logic                 att_r_load_i,
  input logic                 out_valid_o,
  input logic signed [DW-1:0] out_left_o,
  input logic signed [DW-1:0] out_right_o,
  input logic        [CW-1:0] lvl_i,
  input logic        [CW-1:0] act_l_i,
  input logic        [CW-1:0] act_r_i
);
  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  a_r9_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  a_r6_disable_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && disable_i) |=> (out_left_o == '0 && out_right_o == '0));
  a_r7_izd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && izd_en_i && zero_flag_i) |=> (out_left_o == '0 && out_right_o == '0));
  a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lvl_i == $past(lvl_i)) || (lvl_i == $past(lvl_i) + 1) || (lvl_i + 1 == $past(lvl_i)));
  a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(lvl_i));
  a_r2_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((att_l_wr_i && att_l_load_i) || (att_r_wr_i && att_r_load_i)) |=> ($stable(act_l_i) && $stable(act_r_i)));
endmodule

bind stereo_gain_mix sgm_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .disable_i(disable_i), .izd_en_i(izd_en_i), .zero_flag_i(zero_flag_i),
  .att_l_wr_i(att_l_wr_i), .att_l_load_i(att_l_load_i),
  .att_r_wr_i(att_r_wr_i), .att_r_load_i(att_r_load_i),
  .out_valid_o(out_valid_o), .out_left_o(out_left_o), .out_right_o(out_right_o),
  .lvl_i(mute_lvl), .act_l_i(act_l), .act_r_i(act_r)
);

// File: tb/stereo_gain_mix_test.sv
module stereo_gain_mix_test;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int MAXC = (1 << CW) - 1;
  localparam longint UNI = longint'(1) << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_l = '0, in_r = '0;
  logic att_l_wr = 1'b0, att_l_ld = 1'b0, att_r_wr = 1'b0, att_r_ld = 1'b0;
  logic [CW-1:0] att_l_code = '0, att_r_code = '0;
  logic common = 1'b0;
  logic [3:0] mode = 4'b0110;
  logic mute = 1'b0, dis = 1'b0, izd_en = 1'b0, zflag = 1'b0;
  logic out_valid_o;
  logic signed [DW-1:0] out_left_o, out_right_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side model state
  int m_pend_l = MAXC, m_pend_r = MAXC, m_act_l = MAXC, m_act_r = MAXC, m_lvl = MAXC;
  logic signed [DW-1:0] q_l[$];
  logic signed [DW-1:0] q_r[$];
  string q_tag[$];
  logic signed [DW-1:0] last_l = '0, last_r = '0;

  always #10 clk = ~clk;

  stereo_gain_mix #(.DW(DW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
    .in_left_i(in_l), .in_right_i(in_r),
    .att_l_wr_i(att_l_wr), .att_l_code_i(att_l_code), .att_l_load_i(att_l_ld),
    .att_r_wr_i(att_r_wr), .att_r_code_i(att_r_code), .att_r_load_i(att_r_ld),
    .att_common_i(common), .route_mode_i(mode), .mute_i(mute),
    .disable_i(dis), .izd_en_i(izd_en), .zero_flag_i(zflag),
    .out_valid_o(out_valid_o), .out_left_o(out_left_o), .out_right_o(out_right_o)
  );

  function automatic longint scale(longint s, int code);
    longint g = (code == MAXC) ? UNI : longint'(code);
    return (s * g) >>> CW;
  endfunction

  function automatic longint pick(int sel, longint l, longint r);
    case (sel)
      0: return 0;
      1: return r;
      2: return l;
      default: return (l + r) >>> 1;
    endcase
  endfunction

  task automatic send(input longint l, input longint r, input string tag);
    longint el, er;
    int cl, cr;
    @(negedge clk);
    in_l = DW'(l); in_r = DW'(r); in_valid = 1'b1;
    cl = m_act_l;
    cr = common ? m_act_l : m_act_r;
    el = scale(scale(pick(int'(mode[1:0]), l, r), cl), m_lvl);
    er = scale(scale(pick(int'(mode[3:2]), l, r), cr), m_lvl);
    if (dis || (izd_en && zflag)) begin el = 0; er = 0; end
    q_l.push_back(DW'(el)); q_r.push_back(DW'(er)); q_tag.push_back(tag);
    if (mute && m_lvl > 0) m_lvl--;
    else if (!mute && m_lvl < MAXC) m_lvl++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic write_att(input bit right, input int code, input bit ld);
    @(negedge clk);
    if (right) begin att_r_wr = 1'b1; att_r_code = CW'(code); att_r_ld = ld; m_pend_r = code; end
    else       begin att_l_wr = 1'b1; att_l_code = CW'(code); att_l_ld = ld; m_pend_l = code; end
    if (ld) begin m_act_l = m_pend_l; m_act_r = m_pend_r; end
    @(negedge clk);
    att_l_wr = 1'b0; att_r_wr = 1'b0; att_l_ld = 1'b0; att_r_ld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard compare
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (q_l.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected out_valid_o: actual 1 expected 0");
      end else begin
        logic signed [DW-1:0] el, er;
        string tg;
        el = q_l.pop_front(); er = q_r.pop_front(); tg = q_tag.pop_front();
        checks++;
        last_l = el; last_r = er;
        if (out_left_o !== el || out_right_o !== er) begin
          errors++;
          $display("FAIL %s actual %0d/%0d expected %0d/%0d", tg, out_left_o, out_right_o, el, er);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R8: outputs idle after reset
    checks++;
    if (out_valid_o !== 1'b0 || out_left_o !== '0 || out_right_o !== '0) begin
      errors++;
      $display("FAIL R8 reset outputs actual %b %0d %0d expected 0 0 0", out_valid_o, out_left_o, out_right_o);
    end
    send(1000, -2000, "R8");            // unity defaults pass samples through
    send(-32768, 32767, "R8");

    // R1: gain law
    write_att(0, 8, 1);
    send(1000, -2000, "R1");
    write_att(0, 0, 1);
    send(1000, -2000, "R1");
    write_att(0, 1, 1);
    send(-1001, 999, "R1");
    write_att(0, 14, 1);
    send(-32768, 32767, "R1");

    // R2: write without load keeps active codes
    write_att(1, 4, 0);
    send(1600, 1600, "R2");
    write_att(0, MAXC, 1);              // loads right pending too
    send(1600, 1600, "R2");
    write_att(1, 2, 0);
    write_att(0, 6, 0);
    send(1600, -1600, "R2");
    write_att(1, 2, 1);                 // loads both pendings
    send(1600, -1600, "R2");

    // R3: common gain
    common = 1'b1;
    send(1600, -1600, "R3");
    common = 1'b0;
    send(1600, -1600, "R3");
    write_att(0, MAXC, 0);
    write_att(1, MAXC, 1);

    // R4: all routing modes
    for (int m = 0; m < 16; m++) begin
      mode = 4'(m);
      send(301, -4, "R4");
      send(-301, 0, "R4");
    end
    mode = 4'b1111;
    send(32767, 32767, "R4");
    send(-32768, -32768, "R4");
    mode = 4'b0110;

    // R5: soft mute down then up
    mute = 1'b1;
    for (int i = 0; i < 20; i++) send(-32768, 20000, "R5");
    mute = 1'b0;
    for (int i = 0; i < 20; i++) send(-32768, 20000, "R5");

    // R6: disable forces zero
    dis = 1'b1;
    send(5000, -5000, "R6");
    dis = 1'b0;
    send(5000, -5000, "R6");

    // R7: zero flag only with enable
    zflag = 1'b1;
    send(777, -777, "R7");
    izd_en = 1'b1;
    send(777, -777, "R7");
    zflag = 1'b0;
    send(777, -777, "R7");
    izd_en = 1'b0;

    // R9: outputs hold with no samples
    idle(4);
    checks++;
    if (out_valid_o !== 1'b0 || out_left_o !== last_l || out_right_o !== last_r) begin
      errors++;
      $display("FAIL R9 hold actual %b %0d %0d expected 0 %0d %0d", out_valid_o, out_left_o, out_right_o, last_l, last_r);
    end
    checks++;
    if (q_l.size() != 0) begin
      errors++;
      $display("FAIL R9 missing outputs actual %0d pending expected 0", q_l.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule